// File: doc/BRIEF.md
# Slave-Side Master Acquisition Controller

This block runs on a mobile radio node and decides when the node may use its link to the stationary master. After reset, or when the surrounding logic asks for a re-acquisition, it walks a channel-select output through every radio channel. It stays on each channel for a fixed dwell and listens for a master frame that arrived intact on both redundant receivers and carries an acceptable master ID. When such a frame is heard, the channel is frozen. The block then waits for a second frame from the same master to confirm synchronisation, and after that opens a long qualification window.

During qualification the block counts received packets and packets lost on both receivers. The link is accepted only when the full packet count is reached with fewer errors than the budget. When the budget is used up, the attempt is abandoned at once and a fresh search begins. On acceptance the master ID and the slave ID assigned to this node are kept. The next acquisition first tries only that remembered master for one full channel sweep, and falls back to the open search if that attempt fails. The open search accepts only a small low range of master IDs, while a remembered master may carry any non-zero ID.

Top module: `link_acquire`

## Requirements
- R1: While searching, `chan_sel` advances by one every DWELL_CYCLES clock cycles and wraps from NUM_CH-1 to 0. It holds its value in every other phase.
- R2: In the open search, a frame counts as a detection only when `rx_valid` is high with both `rx_crc_ok_a` and `rx_crc_ok_b` high and `rx_master_id` in 1..SEARCH_MAX_ID. A detection freezes the channel.
- R3: During the open search, frames with master ID 0, with an ID above SEARCH_MAX_ID, or with only one CRC good are ignored, and channel stepping continues.
- R4: After a detection, a frame with the same master ID and at least one good CRC starts qualification. If no such frame arrives within SYNC_CYCLES cycles, a new search starts.
- R5: In qualification every `rx_valid` is one packet, and a packet with both CRC flags low is an error. `link_up` rises in the cycle after the QUAL_PKTS-th packet if fewer than ERR_LIMIT errors were seen.
- R6: Reaching ERR_LIMIT errors aborts qualification in the cycle of the failing packet and restarts the search. When that packet is also the QUAL_PKTS-th, the failure wins.
- R7: On acceptance, `stored_master_id` takes the qualified master ID and `stored_slave_id` takes `slave_id_in`.
- R8: `resync_req` drops `link_up` in the next cycle and starts a new acquisition. With valid stored IDs this acquisition tries only the stored master (both CRCs good), and no search-restart pulse is issued.
- R9: A remembered-master attempt that hears no matching frame during NUM_CH dwells, or that fails sync or qualification, falls back to the open search.
- R10: When a stored ID is zero, acquisition skips the remembered-master attempt and goes straight to the open search.
- R11: `search_restart` is a one-cycle pulse, issued on each entry into the open search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the stored IDs |
| rx_valid | input | 1 | One received frame or packet this cycle |
| rx_crc_ok_a | input | 1 | CRC good on receiver A for this frame |
| rx_crc_ok_b | input | 1 | CRC good on receiver B for this frame |
| rx_master_id | input | MID_W | Master ID carried by the frame |
| slave_id_in | input | SID_W | Slave ID assigned to this node, captured on acceptance |
| resync_req | input | 1 | Drop the link and acquire again |
| link_up | output | 1 | Link qualified; normal traffic allowed |
| chan_sel | output | CH_W | Current radio channel |
| stored_master_id | output | MID_W | Master ID from the last accepted link |
| stored_slave_id | output | SID_W | Slave ID from the last accepted link |
| search_restart | output | 1 | Pulse on each entry into the open search |

## Verification
Two events can meet in one cycle inside qualification: the packet that completes the window can also be the one that uses up the error budget. The bench provokes this by sending one packet less than the window with one error less than the budget, then an erroneous final packet. It expects a restart pulse and no link. A second run with a clean final packet expects the link to rise. A further collision, between the end of a channel dwell and an arriving detection frame, is judged by checking that the channel stays frozen afterwards.

// File: rtl/link_acq_pkg.sv
package link_acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RECALL = 3'd1,
    ST_SEARCH = 3'd2,
    ST_SYNC   = 3'd3,
    ST_QUAL   = 3'd4,
    ST_LINK   = 3'd5
  } acq_state_t;

endpackage

// File: rtl/chan_dwell_scan.sv
module chan_dwell_scan #(
  parameter int NUM_CH       = 40,
  parameter int DWELL_CYCLES = 2_000_000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DW_W = $clog2(DWELL_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_en,
  output logic [CH_W-1:0] chan_o,
  output logic            step_o
);

  logic [DW_W-1:0] dwell_q;
  logic [CH_W-1:0] chan_q;
  logic            dwell_end;

  assign dwell_end = (dwell_q == DW_W'(DWELL_CYCLES - 1));
  assign step_o    = scan_en && dwell_end;
  assign chan_o    = chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell_q <= '0;
      chan_q  <= '0;
    end else if (!scan_en) begin
      dwell_q <= '0;
    end else if (dwell_end) begin
      dwell_q <= '0;
      if (chan_q == CH_W'(NUM_CH - 1)) chan_q <= '0;
      else                             chan_q <= chan_q + 1'b1;
    end else begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    chan_q < CH_W'(NUM_CH)) else $error("channel out of range");  // R1

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> $stable(chan_q)) else $error("channel moved while frozen");  // R1

endmodule

// File: rtl/qual_window.sv
module qual_window #(
  parameter int QUAL_PKTS = 10000,
  parameter int ERR_LIMIT = 20,
  localparam int PK_W = $clog2(QUAL_PKTS + 1),
  localparam int ER_W = $clog2(ERR_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic pkt,
  input  logic pkt_err,
  output logic pass_o,
  output logic fail_o
);

  logic [PK_W-1:0] pkt_q;
  logic [ER_W-1:0] err_q;
  logic            last_err;
  logic            last_pkt;

  assign last_err = (err_q == ER_W'(ERR_LIMIT - 1));
  assign last_pkt = (pkt_q == PK_W'(QUAL_PKTS - 1));
  assign fail_o   = active && pkt && pkt_err && last_err;
  assign pass_o   = active && pkt && !fail_o && last_pkt;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pkt_q <= '0;
      err_q <= '0;
    end else if (pkt) begin
      if (!last_pkt)             pkt_q <= pkt_q + 1'b1;
      if (pkt_err && !last_err)  err_q <= err_q + 1'b1;
    end
  end

  AST_ERR_BUDGET: assert property (@(posedge clk) disable iff (rst)
    err_q < ER_W'(ERR_LIMIT)) else $error("error count beyond budget");  // R6

  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (rst)
    pkt_q < PK_W'(QUAL_PKTS)) else $error("packet count beyond window");  // R5

endmodule

// File: rtl/id_memory.sv
module id_memory #(
  parameter int MID_W = 8,
  parameter int SID_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             store,
  input  logic [MID_W-1:0] mid_in,
  input  logic [SID_W-1:0] sid_in,
  output logic [MID_W-1:0] mid_o,
  output logic [SID_W-1:0] sid_o,
  output logic             valid_o
);

  logic [MID_W-1:0] mid_q;
  logic [SID_W-1:0] sid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q <= '0;
      sid_q <= '0;
    end else if (store) begin
      mid_q <= mid_in;
      sid_q <= sid_in;
    end
  end

  assign mid_o   = mid_q;
  assign sid_o   = sid_q;
  assign valid_o = (mid_q != '0) && (sid_q != '0);

  AST_STORE_TAKES: assert property (@(posedge clk) disable iff (rst)
    store |=> (mid_o == $past(mid_in)) && (sid_o == $past(sid_in)))
    else $error("stored IDs not captured");  // R7

endmodule

// File: rtl/link_acquire.sv
module link_acquire
  import link_acq_pkg::*;
#(
  parameter int NUM_CH        = 40,
  parameter int DWELL_CYCLES  = 2_000_000,
  parameter int SYNC_CYCLES   = 4_000_000,
  parameter int QUAL_PKTS     = 10000,
  parameter int ERR_LIMIT     = 20,
  parameter int SEARCH_MAX_ID = 10,
  parameter int MID_W         = 8,
  parameter int SID_W         = 6,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_crc_ok_a,
  input  logic             rx_crc_ok_b,
  input  logic [MID_W-1:0] rx_master_id,
  input  logic [SID_W-1:0] slave_id_in,
  input  logic             resync_req,
  output logic             link_up,
  output logic [CH_W-1:0]  chan_sel,
  output logic [MID_W-1:0] stored_master_id,
  output logic [SID_W-1:0] stored_slave_id,
  output logic             search_restart
);

  localparam int SY_W = $clog2(SYNC_CYCLES + 1);
  localparam int RS_W = $clog2(NUM_CH + 1);

  acq_state_t       state_q, state_n;
  logic [MID_W-1:0] cand_q;
  logic [SY_W-1:0]  sync_cnt_q;
  logic [RS_W-1:0]  sweep_q;
  logic             link_q;
  logic             restart_q;

  logic scan_en, step;
  logic both_ok, any_ok, in_range;
  logic search_hit, recall_hit, sync_hit;
  logic pkt_err, qual_pass, qual_fail;
  logic ids_valid, store;
  logic sweep_done, sync_timeout;

  assign scan_en  = (state_q == ST_SEARCH) || (state_q == ST_RECALL);
  assign both_ok  = rx_crc_ok_a && rx_crc_ok_b;
  assign any_ok   = rx_crc_ok_a || rx_crc_ok_b;
  assign pkt_err  = !rx_crc_ok_a && !rx_crc_ok_b;
  assign in_range = (rx_master_id != '0) && (rx_master_id <= MID_W'(SEARCH_MAX_ID));

  assign search_hit = rx_valid && both_ok && in_range;
  assign recall_hit = rx_valid && both_ok && (rx_master_id == stored_master_id);
  assign sync_hit   = rx_valid && any_ok && (rx_master_id == cand_q);

  assign sweep_done   = step && (sweep_q == RS_W'(NUM_CH - 1));
  assign sync_timeout = (sync_cnt_q == SY_W'(SYNC_CYCLES - 1));

  chan_dwell_scan #(
    .NUM_CH       (NUM_CH),
    .DWELL_CYCLES (DWELL_CYCLES)
  ) u_scan (
    .clk     (clk),
    .rst     (rst),
    .scan_en (scan_en),
    .chan_o  (chan_sel),
    .step_o  (step)
  );

  qual_window #(
    .QUAL_PKTS (QUAL_PKTS),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_qual (
    .clk     (clk),
    .rst     (rst),
    .active  (state_q == ST_QUAL),
    .pkt     (rx_valid),
    .pkt_err (pkt_err),
    .pass_o  (qual_pass),
    .fail_o  (qual_fail)
  );

  assign store = (state_q == ST_QUAL) && (state_n == ST_LINK);

  id_memory #(
    .MID_W (MID_W),
    .SID_W (SID_W)
  ) u_ids (
    .clk     (clk),
    .rst     (rst),
    .store   (store),
    .mid_in  (cand_q),
    .sid_in  (slave_id_in),
    .mid_o   (stored_master_id),
    .sid_o   (stored_slave_id),
    .valid_o (ids_valid)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:   state_n = ids_valid ? ST_RECALL : ST_SEARCH;
      ST_RECALL: begin
        if (recall_hit)      state_n = ST_SYNC;
        else if (sweep_done) state_n = ST_SEARCH;
      end
      ST_SEARCH: if (search_hit) state_n = ST_SYNC;
      ST_SYNC: begin
        if (sync_hit)          state_n = ST_QUAL;
        else if (sync_timeout) state_n = ST_SEARCH;
      end
      ST_QUAL: begin
        if (qual_fail)      state_n = ST_SEARCH;
        else if (qual_pass) state_n = ST_LINK;
      end
      ST_LINK:   state_n = ST_LINK;
      default:   state_n = ST_IDLE;
    endcase
    if (resync_req) state_n = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cand_q     <= '0;
      sync_cnt_q <= '0;
      sweep_q    <= '0;
      link_q     <= 1'b0;
      restart_q  <= 1'b0;
    end else begin
      state_q   <= state_n;
      link_q    <= (state_n == ST_LINK);
      restart_q <= (state_n == ST_SEARCH) && (state_q != ST_SEARCH);

      if ((state_q == ST_SEARCH && search_hit) || (state_q == ST_RECALL && recall_hit))
        cand_q <= rx_master_id;

      if (state_q == ST_SYNC) sync_cnt_q <= sync_cnt_q + 1'b1;
      else                    sync_cnt_q <= '0;

      if (state_q != ST_RECALL) sweep_q <= '0;
      else if (step)            sweep_q <= sweep_q + 1'b1;
    end
  end

  assign link_up        = link_q;
  assign search_restart = restart_q;

  AST_LINK_FROM_PASS: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> $past(qual_pass)) else $error("link without qualification");  // R5

  AST_RESYNC_DROPS: assert property (@(posedge clk) disable iff (rst)
    resync_req |=> !link_up) else $error("link held over resync");  // R8

  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    search_restart |=> !search_restart) else $error("restart wider than a cycle");  // R11

  AST_FAIL_NO_LINK: assert property (@(posedge clk) disable iff (rst)
    qual_fail && !resync_req |=> !link_up && search_restart)
    else $error("failed window did not restart");  // R6

endmodule

// File: tb/link_acquire_test.sv
`timescale 1ns/1ps
module link_acquire_test;

  localparam int NCH = 5;
  localparam int DW  = 8;
  localparam int SY  = 20;
  localparam int QP  = 30;
  localparam int EL  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic       rx_crc_ok_a = 1'b0;
  logic       rx_crc_ok_b = 1'b0;
  logic [7:0] rx_master_id = '0;
  logic [5:0] slave_id_in = '0;
  logic       resync_req = 1'b0;
  logic       link_up;
  logic [2:0] chan_sel;
  logic [7:0] stored_master_id;
  logic [5:0] stored_slave_id;
  logic       search_restart;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  link_acquire #(
    .NUM_CH(NCH), .DWELL_CYCLES(DW), .SYNC_CYCLES(SY),
    .QUAL_PKTS(QP), .ERR_LIMIT(EL), .SEARCH_MAX_ID(10),
    .MID_W(8), .SID_W(6)
  ) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_crc_ok_a(rx_crc_ok_a),
    .rx_crc_ok_b(rx_crc_ok_b), .rx_master_id(rx_master_id),
    .slave_id_in(slave_id_in), .resync_req(resync_req), .link_up(link_up),
    .chan_sel(chan_sel), .stored_master_id(stored_master_id),
    .stored_slave_id(stored_slave_id), .search_restart(search_restart)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input int id, input bit a, input bit b);
    @(negedge clk);
    rx_valid = 1'b1; rx_master_id = 8'(id); rx_crc_ok_a = a; rx_crc_ok_b = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_crc_ok_a = 1'b0; rx_crc_ok_b = 1'b0;
  endtask

  task automatic count_restarts(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (search_restart) cnt++;
    end
  endtask

  task automatic wait_chan_change(output int cyc);
    logic [2:0] c0;
    c0 = chan_sel;
    cyc = 0;
    while (chan_sel == c0 && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic acquire(input int id);
    send_pkt(id, 1, 1);
    send_pkt(id, 1, 0);
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!link_up && chan_sel == 0, "R1 reset link/channel", {link_up, chan_sel}, 0);
    check(stored_master_id == 0 && stored_slave_id == 0, "R7 reset IDs",
          stored_master_id, 0);
    rst = 1'b0;
    count_restarts(4, n);
    check(n == 1, "R10 R11 direct search after reset", n, 1);
  endtask

  task automatic t_step();
    int c;
    logic [2:0] prev;
    wait_chan_change(c);
    wait_chan_change(c);
    check(c == DW, "R1 dwell length", c, DW);
    while (chan_sel != 3'(NCH - 1)) @(negedge clk);
    prev = chan_sel;
    wait_chan_change(c);
    check(prev == 3'(NCH - 1) && chan_sel == 0, "R1 wrap", chan_sel, 0);
  endtask

  task automatic t_ignore();
    int c;
    logic [2:0] c0;
    wait_chan_change(c);
    c0 = chan_sel;
    send_pkt(0, 1, 1);
    send_pkt(11, 1, 1);
    send_pkt(5, 1, 0);
    repeat (4) @(negedge clk);
    check(chan_sel != c0, "R3 ignored frames keep scanning", chan_sel, c0 + 1);
  endtask

  task automatic t_detect_timeout();
    logic [2:0] c0;
    int n;
    send_pkt(5, 1, 1);
    c0 = chan_sel;
    repeat (12) @(negedge clk);
    check(chan_sel == c0, "R2 channel frozen on detection", chan_sel, c0);
    count_restarts(20, n);
    check(n == 1, "R4 sync timeout restarts search", n, 1);
  endtask

  task automatic t_fail_early();
    acquire(5);
    for (int i = 0; i < EL; i++) send_pkt(5, 0, 0);
    check(search_restart == 1'b1, "R6 abort at error budget", search_restart, 1);
    check(!link_up, "R6 no link after abort", link_up, 0);
    @(negedge clk);
    check(search_restart == 1'b0, "R11 restart pulse one cycle", search_restart, 0);
  endtask

  task automatic t_conflict();
    acquire(6);
    for (int i = 0; i < QP - EL; i++) send_pkt(6, 1, 0);
    for (int i = 0; i < EL - 1; i++) send_pkt(6, 0, 0);
    send_pkt(6, 0, 0);
    check(search_restart && !link_up, "R6 error wins on last packet",
          {link_up, search_restart}, 1);
  endtask

  task automatic t_pass(input int mid, input int sid);
    slave_id_in = 6'(sid);
    acquire(mid);
    for (int i = 0; i < EL - 1; i++) send_pkt(mid, 0, 0);
    for (int i = 0; i < QP - EL; i++) send_pkt(mid, 0, 1);
    check(!link_up, "R5 no link before window ends", link_up, 0);
    send_pkt(mid, 1, 1);
    check(link_up, "R5 link after full window", link_up, 1);
    check(stored_master_id == 8'(mid), "R7 stored master", stored_master_id, mid);
    check(stored_slave_id == 6'(sid), "R7 stored slave", stored_slave_id, sid);
  endtask

  task automatic t_recall();
    int n;
    int c;
    logic [2:0] c0;
    @(negedge clk); resync_req = 1'b1;
    @(negedge clk); resync_req = 1'b0;
    check(!link_up, "R8 resync drops link", link_up, 0);
    count_restarts(4, n);
    check(n == 0, "R8 recall without restart pulse", n, 0);
    wait_chan_change(c);
    c0 = chan_sel;
    send_pkt(3, 1, 1);
    repeat (6) @(negedge clk);
    check(chan_sel != c0, "R8 recall ignores other master", chan_sel, c0 + 1);
    send_pkt(7, 1, 1);
    c0 = chan_sel;
    repeat (10) @(negedge clk);
    check(chan_sel == c0, "R8 recall locks stored master", chan_sel, c0);
    send_pkt(7, 1, 0);
    for (int i = 0; i < EL; i++) send_pkt(7, 0, 0);
    check(search_restart, "R9 failed recall qualification", search_restart, 1);
  endtask

  task automatic t_recall_timeout();
    int n;
    @(negedge clk); resync_req = 1'b1;
    @(negedge clk); resync_req = 1'b0;
    count_restarts(30, n);
    check(n == 0, "R9 no restart during recall sweep", n, 0);
    count_restarts(30, n);
    check(n == 1, "R9 sweep exhausted falls back", n, 1);
  endtask

  initial begin
    t_reset();
    t_step();
    t_ignore();
    t_detect_timeout();
    t_fail_early();
    t_conflict();
    t_pass(7, 9);
    t_recall();
    t_pass(8, 4);
    t_recall_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule